// File: doc/BRIEF.md
# Clock Prescaler Controller With Ready Flag

This block turns a main clock into a set of slower domain clocks: one for the CPU, one for the high-speed bus and one per peripheral bus. Each domain clock is a single-cycle clock-enable pulse taken from one shared free-running counter. With division on, a domain ticks once every 2^(SEL+1) main-clock cycles. With division off, it ticks on every cycle. All domains are taken from the same counter, so they stay phase-aligned. A per-module mask then gates each domain's enable pulse before it reaches a module.

Software programs the block through a small register port. The port has a synchronous write strobe and a combinational read path. A write to a divider select register starts a change. Until the change is complete, the ready bit in the status register reads zero and any further select writes are dropped. The new setting is applied only at a counter wrap, and the ready bit returns one cycle later.

The hardware enforces two rules on every change:
- the bus clock always shares the CPU divider;
- a peripheral divider that would run faster than the CPU is replaced by the CPU setting, and the stored value is rewritten.

The rising edge of the ready bit latches an interrupt status flag. The flag raises the interrupt line when its mask bit is set.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset: the status register reads 1 (ready), every select register reads 0 (division off), every module mask reads all ones, the interrupt mask and status read 0, irq is 0, and every domain and module enable is 1 on every cycle.
- R2: Select register layout: bit 7 enables division and bits 2:0 hold SEL. With division on, a domain's enable pulses exactly when the low SEL+1 bits of the free-running counter are all ones, giving one pulse every 2^(SEL+1) cycles. With division off, it pulses on every cycle.
- R3: bus_ce equals cpu_ce on every cycle, for every CPU setting.
- R4: When a change is applied, each peripheral divider whose exponent (0 when off, SEL+1 when on) is below the CPU exponent is replaced by the CPU setting. The select register then reads back the replaced value.
- R5: An accepted select write clears the ready bit (status address 4, bit 0) from the next cycle on. The setting takes effect at the next counter wrap (all ones to zero). Ready reads 1 again one cycle after that wrap, which is the cycle in which the counter holds 1.
- R6: Select writes made while ready is 0 are ignored: they change no select value and do not start another change.
- R7: The interrupt status bit (address 8, bit 0) is set in the same cycle that ready rises. Writing 1 to bit 0 at address 9 clears it.
- R8: Writing 1 to bit 0 at address 5 sets the interrupt mask bit (read at address 7), and writing 1 to bit 0 at address 6 clears it. irq is 1 exactly while both the mask bit and the status bit are 1.
- R9: Module masks are at addresses 10 (CPU), 11 (bus) and 12+i (peripheral i). Each module enable is its domain's enable ANDed with its mask bit. Writing 0 stops that module's enable, and writing 1 restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cpu_ce | output | 1 | CPU domain clock enable |
| bus_ce | output | 1 | High-speed bus domain clock enable |
| pb_ce | output | NUM_PB | Peripheral bus domain clock enables |
| cpu_mod_ce | output | CPU_MODS | Masked CPU module enables |
| bus_mod_ce | output | BUS_MODS | Masked bus module enables |
| pb_mod_ce | output | NUM_PB*PB_MODS | Masked peripheral module enables, domain i at bits i*PB_MODS upward |
| irq | output | 1 | Clock-change-complete interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a select write that arrives while a change is still waiting for the counter wrap. The bench produces it by issuing further select writes on the cycles right after an accepted one. It then checks that the first value survives and that ready stays high afterwards. The second is the alignment of a new setting to the counter wrap, since the counter is not visible at the ports. The bench infers the alignment from the cycle in which ready rises: it checks the offset of the first pulse, the spacing between pulses and the pulse count over a full counter period. It does this for every pair of CPU and peripheral divider settings.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int SEL_W   = 3;
    localparam int EXP_MAX = 1 << SEL_W;
    localparam int CNT_W   = EXP_MAX;
    localparam int EXP_W   = $clog2(EXP_MAX + 1);
    localparam int DW      = 8;
    localparam int AW      = 4;

    localparam logic [AW-1:0] A_CPU_SEL  = 4'd0;
    localparam logic [AW-1:0] A_PB_SEL0  = 4'd1;
    localparam logic [AW-1:0] A_STATUS   = 4'd4;
    localparam logic [AW-1:0] A_IEN      = 4'd5;
    localparam logic [AW-1:0] A_IDIS     = 4'd6;
    localparam logic [AW-1:0] A_IMASK    = 4'd7;
    localparam logic [AW-1:0] A_ISTAT    = 4'd8;
    localparam logic [AW-1:0] A_ICLR     = 4'd9;
    localparam logic [AW-1:0] A_CPU_MASK = 4'd10;
    localparam logic [AW-1:0] A_BUS_MASK = 4'd11;
    localparam logic [AW-1:0] A_PB_MASK0 = 4'd12;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } divsel_t;

    typedef enum logic [1:0] {
        ST_READY,
        ST_WAIT_WRAP,
        ST_SETTLE
    } chg_state_e;

    function automatic divsel_t byte_to_sel(logic [DW-1:0] d);
        divsel_t r;
        r.en  = d[DW-1];
        r.sel = d[SEL_W-1:0];
        return r;
    endfunction

    function automatic logic [DW-1:0] sel_to_byte(divsel_t s);
        return {s.en, {(DW-1-SEL_W){1'b0}}, s.sel};
    endfunction

    // division exponent: 0 = undivided, otherwise SEL+1
    function automatic logic [EXP_W-1:0] sel_to_exp(divsel_t s);
        return s.en ? EXP_W'(s.sel) + EXP_W'(1) : '0;
    endfunction

    function automatic divsel_t exp_to_sel(logic [EXP_W-1:0] e);
        divsel_t r;
        if (e == '0) begin
            r = '0;
        end else begin
            r.en  = 1'b1;
            r.sel = SEL_W'(e - EXP_W'(1));
        end
        return r;
    endfunction

    function automatic divsel_t clamp_pb(divsel_t cpu, divsel_t pb);
        logic [EXP_W-1:0] ec;
        logic [EXP_W-1:0] ep;
        ec = sel_to_exp(cpu);
        ep = sel_to_exp(pb);
        return (ep < ec) ? exp_to_sel(ec) : pb;
    endfunction

    function automatic logic tick(logic [CNT_W-1:0] c, logic [EXP_W-1:0] e);
        logic [CNT_W:0] m;
        m = ({{CNT_W{1'b0}}, 1'b1} << e) - (CNT_W+1)'(1);
        return (({1'b0, c} & m) == m);
    endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int NUM_PB   = 2,
    parameter int CPU_MODS = 4,
    parameter int BUS_MODS = 4,
    parameter int PB_MODS  = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [AW-1:0]                      wr_addr,
    input  logic [DW-1:0]                      wr_data,
    input  logic [AW-1:0]                      rd_addr,
    output logic [DW-1:0]                      rd_data,
    input  logic                               wrap,
    output divsel_t                            cpu_act,
    output divsel_t [NUM_PB-1:0]               pb_act,
    output logic [CPU_MODS-1:0]                cpu_mask,
    output logic [BUS_MODS-1:0]                bus_mask,
    output logic [NUM_PB-1:0][PB_MODS-1:0]     pb_mask,
    output logic                               irq
);
    chg_state_e            state;
    divsel_t               cpu_new;
    divsel_t [NUM_PB-1:0]  pb_new;
    logic                  imask_q;
    logic                  istat_q;
    logic                  ready;
    logic [NUM_PB-1:0]     pb_hit;
    logic [NUM_PB-1:0]     pbm_hit;
    logic                  sel_hit;
    logic                  unused_bits;

    assign unused_bits = ^wr_data;
    assign ready       = (state == ST_READY);

    always_comb begin
        for (int i = 0; i < NUM_PB; i++) begin
            pb_hit[i]  = (wr_addr == A_PB_SEL0 + AW'(i));
            pbm_hit[i] = (wr_addr == A_PB_MASK0 + AW'(i));
        end
    end

    assign sel_hit = wr_en && ready && ((wr_addr == A_CPU_SEL) || (|pb_hit));

    // change sequencer: accept, wait for wrap, settle one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_READY;
            cpu_new <= '0;
            cpu_act <= '0;
            pb_new  <= '0;
            pb_act  <= '0;
        end else begin
            unique case (state)
                ST_READY: begin
                    if (sel_hit) begin
                        state <= ST_WAIT_WRAP;
                        if (wr_addr == A_CPU_SEL) cpu_new <= byte_to_sel(wr_data);
                        for (int i = 0; i < NUM_PB; i++)
                            if (pb_hit[i]) pb_new[i] <= byte_to_sel(wr_data);
                    end
                end
                ST_WAIT_WRAP: begin
                    if (wrap) begin
                        state   <= ST_SETTLE;
                        cpu_act <= cpu_new;
                        for (int i = 0; i < NUM_PB; i++) begin
                            pb_new[i] <= clamp_pb(cpu_new, pb_new[i]);
                            pb_act[i] <= clamp_pb(cpu_new, pb_new[i]);
                        end
                    end
                end
                ST_SETTLE: state <= ST_READY;
                default:   state <= ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_mask <= '1;
            bus_mask <= '1;
            pb_mask  <= '1;
        end else if (wr_en) begin
            if (wr_addr == A_CPU_MASK) cpu_mask <= wr_data[CPU_MODS-1:0];
            if (wr_addr == A_BUS_MASK) bus_mask <= wr_data[BUS_MODS-1:0];
            for (int i = 0; i < NUM_PB; i++)
                if (pbm_hit[i]) pb_mask[i] <= wr_data[PB_MODS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            imask_q <= 1'b0;
            istat_q <= 1'b0;
        end else begin
            if (state == ST_SETTLE)
                istat_q <= 1'b1;
            else if (wr_en && wr_addr == A_ICLR && wr_data[0])
                istat_q <= 1'b0;
            if (wr_en && wr_addr == A_IEN && wr_data[0])
                imask_q <= 1'b1;
            else if (wr_en && wr_addr == A_IDIS && wr_data[0])
                imask_q <= 1'b0;
        end
    end

    assign irq = imask_q & istat_q;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CPU_SEL:  rd_data = sel_to_byte(cpu_act);
            A_STATUS:   rd_data = DW'(ready);
            A_IMASK:    rd_data = DW'(imask_q);
            A_ISTAT:    rd_data = DW'(istat_q);
            A_CPU_MASK: rd_data = DW'(cpu_mask);
            A_BUS_MASK: rd_data = DW'(bus_mask);
            default:    rd_data = '0;
        endcase
        for (int i = 0; i < NUM_PB; i++) begin
            if (rd_addr == A_PB_SEL0 + AW'(i))  rd_data = sel_to_byte(pb_act[i]);
            if (rd_addr == A_PB_MASK0 + AW'(i)) rd_data = DW'(pb_mask[i]);
        end
    end
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
    import clkdiv_pkg::*;
#(
    parameter int NUM_PB = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  divsel_t               cpu_sel,
    input  divsel_t [NUM_PB-1:0]  pb_sel,
    output logic                  wrap,
    output logic                  cpu_ce,
    output logic                  bus_ce,
    output logic [NUM_PB-1:0]     pb_ce
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + CNT_W'(1);
    end

    assign wrap   = &cnt;
    assign cpu_ce = tick(cnt, sel_to_exp(cpu_sel));
    assign bus_ce = cpu_ce;

    for (genvar g = 0; g < NUM_PB; g++) begin : g_pb
        assign pb_ce[g] = tick(cnt, sel_to_exp(pb_sel[g]));
    end
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate #(
    parameter int NUM_PB   = 2,
    parameter int CPU_MODS = 4,
    parameter int BUS_MODS = 4,
    parameter int PB_MODS  = 4
) (
    input  logic                            cpu_ce,
    input  logic                            bus_ce,
    input  logic [NUM_PB-1:0]               pb_ce,
    input  logic [CPU_MODS-1:0]             cpu_mask,
    input  logic [BUS_MODS-1:0]             bus_mask,
    input  logic [NUM_PB-1:0][PB_MODS-1:0]  pb_mask,
    output logic [CPU_MODS-1:0]             cpu_mod_ce,
    output logic [BUS_MODS-1:0]             bus_mod_ce,
    output logic [NUM_PB*PB_MODS-1:0]       pb_mod_ce
);
    assign cpu_mod_ce = cpu_mask & {CPU_MODS{cpu_ce}};
    assign bus_mod_ce = bus_mask & {BUS_MODS{bus_ce}};

    for (genvar g = 0; g < NUM_PB; g++) begin : g_pb
        assign pb_mod_ce[g*PB_MODS +: PB_MODS] = pb_mask[g] & {PB_MODS{pb_ce[g]}};
    end
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter int NUM_PB   = 2,
    parameter int CPU_MODS = 4,
    parameter int BUS_MODS = 4,
    parameter int PB_MODS  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [DW-1:0]               wr_data,
    input  logic [AW-1:0]               rd_addr,
    output logic [DW-1:0]               rd_data,
    output logic                        cpu_ce,
    output logic                        bus_ce,
    output logic [NUM_PB-1:0]           pb_ce,
    output logic [CPU_MODS-1:0]         cpu_mod_ce,
    output logic [BUS_MODS-1:0]         bus_mod_ce,
    output logic [NUM_PB*PB_MODS-1:0]   pb_mod_ce,
    output logic                        irq
);
    logic                            wrap;
    divsel_t                         cpu_act;
    divsel_t [NUM_PB-1:0]            pb_act;
    logic [CPU_MODS-1:0]             cpu_mask;
    logic [BUS_MODS-1:0]             bus_mask;
    logic [NUM_PB-1:0][PB_MODS-1:0]  pb_mask;

    clkdiv_regs #(
        .NUM_PB(NUM_PB), .CPU_MODS(CPU_MODS), .BUS_MODS(BUS_MODS), .PB_MODS(PB_MODS)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wrap(wrap),
        .cpu_act(cpu_act), .pb_act(pb_act),
        .cpu_mask(cpu_mask), .bus_mask(bus_mask), .pb_mask(pb_mask), .irq(irq)
    );

    clkdiv_gen #(.NUM_PB(NUM_PB)) u_gen (
        .clk(clk), .rst(rst), .cpu_sel(cpu_act), .pb_sel(pb_act),
        .wrap(wrap), .cpu_ce(cpu_ce), .bus_ce(bus_ce), .pb_ce(pb_ce)
    );

    clkdiv_gate #(
        .NUM_PB(NUM_PB), .CPU_MODS(CPU_MODS), .BUS_MODS(BUS_MODS), .PB_MODS(PB_MODS)
    ) u_gate (
        .cpu_ce(cpu_ce), .bus_ce(bus_ce), .pb_ce(pb_ce),
        .cpu_mask(cpu_mask), .bus_mask(bus_mask), .pb_mask(pb_mask),
        .cpu_mod_ce(cpu_mod_ce), .bus_mod_ce(bus_mod_ce), .pb_mod_ce(pb_mod_ce)
    );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_regs_chk
    import clkdiv_pkg::*;
#(
    parameter int NUM_PB = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input chg_state_e    state,
    input logic          wrap,
    input logic          istat_q,
    input divsel_t       cpu_new
);
    logic rdy;
    logic is_sel;
    assign rdy    = (state == ST_READY);
    assign is_sel = (wr_addr == A_CPU_SEL) ||
                    ((wr_addr >= A_PB_SEL0) && (wr_addr < A_PB_SEL0 + AW'(NUM_PB)));

    assert_busy_on_write_R5: assert property (@(posedge clk) disable iff (rst)
        (rdy && wr_en && is_sel) |=> !rdy)
        else $error("R5: ready did not drop after accepted select write");

    assert_ready_after_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(wrap, 2))
        else $error("R5: ready rose without a wrap two cycles earlier");

    assert_hold_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> $stable(cpu_new))
        else $error("R6: pending CPU select changed during a change");

    assert_flag_on_ready_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> istat_q)
        else $error("R7: interrupt status not set when ready rose");
endmodule

module clkdiv_ctrl_chk #(
    parameter int NUM_PB   = 2,
    parameter int CPU_MODS = 4,
    parameter int BUS_MODS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cpu_ce,
    input logic                 bus_ce,
    input logic [NUM_PB-1:0]    pb_ce,
    input logic [CPU_MODS-1:0]  cpu_mod_ce,
    input logic [BUS_MODS-1:0]  bus_mod_ce
);
    for (genvar g = 0; g < NUM_PB; g++) begin : g_pb
        assert_pb_slower_R4: assert property (@(posedge clk) disable iff (rst)
            pb_ce[g] |-> cpu_ce)
            else $error("R4: peripheral tick without a CPU tick");
    end

    assert_cpu_gated_R9: assert property (@(posedge clk) disable iff (rst)
        (|cpu_mod_ce) |-> cpu_ce)
        else $error("R9: CPU module enable outside a CPU tick");

    assert_bus_gated_R9: assert property (@(posedge clk) disable iff (rst)
        (|bus_mod_ce) |-> bus_ce)
        else $error("R9: bus module enable outside a bus tick");
endmodule

bind clkdiv_regs clkdiv_regs_chk #(.NUM_PB(NUM_PB)) u_regs_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .state(state),
    .wrap(wrap), .istat_q(istat_q), .cpu_new(cpu_new)
);

bind clkdiv_ctrl clkdiv_ctrl_chk #(
    .NUM_PB(NUM_PB), .CPU_MODS(CPU_MODS), .BUS_MODS(BUS_MODS)
) u_ctrl_chk (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .bus_ce(bus_ce), .pb_ce(pb_ce),
    .cpu_mod_ce(cpu_mod_ce), .bus_mod_ce(bus_mod_ce)
);

// File: tb/clkdiv_ctrl_test.sv
module clkdiv_ctrl_test;
    import clkdiv_pkg::*;

    localparam int NUM_PB   = 2;
    localparam int CPU_MODS = 4;
    localparam int BUS_MODS = 4;
    localparam int PB_MODS  = 4;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      wr_en = 1'b0;
    logic [AW-1:0]             wr_addr = '0;
    logic [DW-1:0]             wr_data = '0;
    logic [AW-1:0]             rd_addr = A_STATUS;
    logic [DW-1:0]             rd_data;
    logic                      cpu_ce, bus_ce, irq;
    logic [NUM_PB-1:0]         pb_ce;
    logic [CPU_MODS-1:0]       cpu_mod_ce;
    logic [BUS_MODS-1:0]       bus_mod_ce;
    logic [NUM_PB*PB_MODS-1:0] pb_mod_ce;

    int total = 0;
    int bad   = 0;
    int pb0m  = 0;
    int pb1m  = 0;

    always #4 clk = ~clk;

    clkdiv_ctrl #(
        .NUM_PB(NUM_PB), .CPU_MODS(CPU_MODS), .BUS_MODS(BUS_MODS), .PB_MODS(PB_MODS)
    ) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cpu_ce(cpu_ce), .bus_ce(bus_ce),
        .pb_ce(pb_ce), .cpu_mod_ce(cpu_mod_ce), .bus_mod_ce(bus_mod_ce),
        .pb_mod_ce(pb_mod_ce), .irq(irq)
    );

    function automatic logic [7:0] enc(int e);
        return (e == 0) ? 8'h00 : (8'h80 | 8'(e - 1));
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output int d);
        rd_addr = a;
        #1;
        d = int'(rd_data);
        rd_addr = A_STATUS;
        #1;
    endtask

    // returns at the first cycle where ready reads 1
    task automatic wait_ready(output int low);
        low = 0;
        rd_addr = A_STATUS;
        #1;
        while (rd_data[0] == 1'b0 && low < 1000) begin
            low++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic change(logic [AW-1:0] a, int e);
        int low;
        wr(a, enc(e));
        wait_ready(low);
        check("R5", "ready low cycles within one wrap", int'(low >= 2 && low <= 257), 1);
    endtask

    // measure one full counter period starting at the ready-rise cycle
    task automatic measure(int ec, int e0, int e1);
        int exps[3];
        int first[3];
        int cnt[3];
        int last[3];
        int gaperr[3];
        int busmis;
        logic s[3];
        exps = '{ec, e0, e1};
        busmis = 0;
        for (int d = 0; d < 3; d++) begin
            first[d] = -1; cnt[d] = 0; last[d] = 0; gaperr[d] = 0;
        end
        for (int k = 0; k < 256; k++) begin
            s[0] = cpu_ce; s[1] = pb_ce[0]; s[2] = pb_ce[1];
            if (bus_ce !== cpu_ce) busmis++;
            for (int d = 0; d < 3; d++) begin
                if (s[d]) begin
                    if (first[d] < 0) first[d] = k;
                    else if (k - last[d] != (1 << exps[d])) gaperr[d]++;
                    last[d] = k;
                    cnt[d]++;
                end
            end
            @(negedge clk);
            #1;
        end
        check("R3", "bus/cpu mismatches", busmis, 0);
        for (int d = 0; d < 3; d++) begin
            check("R2", $sformatf("domain %0d pulse count", d), cnt[d], 256 >> exps[d]);
            check("R5", $sformatf("domain %0d first pulse offset", d), first[d],
                  (exps[d] == 0) ? 0 : (1 << exps[d]) - 2);
            check("R2", $sformatf("domain %0d gap errors", d), gaperr[d], 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int v;
        int low;
        int mis;
        int seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd(A_STATUS, v);   check("R1", "status ready", v, 1);
        rd(A_CPU_SEL, v);  check("R1", "cpu select", v, 0);
        rd(A_PB_SEL0, v);  check("R1", "pb0 select", v, 0);
        rd(A_PB_SEL0 + 4'd1, v); check("R1", "pb1 select", v, 0);
        rd(A_CPU_MASK, v); check("R1", "cpu mask", v, 15);
        rd(A_BUS_MASK, v); check("R1", "bus mask", v, 15);
        rd(A_PB_MASK0, v); check("R1", "pb0 mask", v, 15);
        rd(A_PB_MASK0 + 4'd1, v); check("R1", "pb1 mask", v, 15);
        rd(A_IMASK, v);    check("R1", "int mask", v, 0);
        rd(A_ISTAT, v);    check("R1", "int status", v, 0);
        check("R1", "irq", int'(irq), 0);
        mis = 0;
        for (int k = 0; k < 4; k++) begin
            if (!(cpu_ce && bus_ce && (&pb_ce) && (&cpu_mod_ce) && (&bus_mod_ce) && (&pb_mod_ce)))
                mis++;
            @(negedge clk);
            #1;
        end
        check("R1", "enables all high after reset", mis, 0);

        // R2/R4/R5 sweep over all CPU and pb0 exponents
        for (int ec = 0; ec <= 8; ec++) begin
            for (int ep = 0; ep <= 8; ep++) begin
                change(A_CPU_SEL, ec);
                pb0m = imax(pb0m, ec);
                pb1m = imax(pb1m, ec);
                change(A_PB_SEL0, ep);
                pb0m = imax(ep, ec);
                measure(ec, pb0m, pb1m);
                rd(A_CPU_SEL, v); check("R2", "cpu readback", v, int'(enc(ec)));
                rd(A_PB_SEL0, v); check("R4", "pb0 clamped readback", v, int'(enc(pb0m)));
                rd(A_PB_SEL0 + 4'd1, v); check("R4", "pb1 clamped readback", v, int'(enc(pb1m)));
            end
        end
        check("R8", "irq low with mask clear", int'(irq), 0);

        // R6 writes during a pending change are dropped
        change(A_CPU_SEL, 1);
        wr(A_PB_SEL0, enc(3));
        wr(A_PB_SEL0, enc(6));
        wr(A_CPU_SEL, enc(5));
        wait_ready(low);
        rd(A_CPU_SEL, v); check("R6", "cpu select kept", v, int'(enc(1)));
        rd(A_PB_SEL0, v); check("R6", "pb0 select kept", v, int'(enc(3)));
        mis = 0;
        for (int k = 0; k < 300; k++) begin
            if (rd_data[0] !== 1'b1) mis++;
            @(negedge clk);
            #1;
        end
        check("R6", "no second change started", mis, 0);

        // R7/R8 interrupt flow
        wr(A_ICLR, 8'h01);
        rd(A_ISTAT, v); check("R7", "status cleared", v, 0);
        wr(A_IEN, 8'h01);
        rd(A_IMASK, v); check("R8", "mask set", v, 1);
        check("R8", "irq low without status", int'(irq), 0);
        wr(A_CPU_SEL, enc(2));
        check("R7", "irq low while busy", int'(irq), 0);
        wait_ready(low);
        check("R7", "irq with ready rise", int'(irq), 1);
        wr(A_IDIS, 8'h01);
        check("R8", "irq after disable", int'(irq), 0);
        rd(A_ISTAT, v); check("R8", "status kept after disable", v, 1);
        wr(A_IEN, 8'h01);
        check("R8", "irq after re-enable", int'(irq), 1);
        wr(A_ICLR, 8'h01);
        check("R7", "irq after clear", int'(irq), 0);
        rd(A_ISTAT, v); check("R7", "status after clear", v, 0);

        // R9 module masks (cpu exponent 2 now)
        wr(A_CPU_MASK, 8'h05);
        wr(A_BUS_MASK, 8'h03);
        wr(A_PB_MASK0, 8'h08);
        wr(A_PB_MASK0 + 4'd1, 8'h00);
        mis = 0; seen = 0;
        for (int k = 0; k < 64; k++) begin
            if (cpu_mod_ce !== (cpu_ce ? 4'b0101 : 4'b0000)) mis++;
            if (bus_mod_ce !== (bus_ce ? 4'b0011 : 4'b0000)) mis++;
            if (pb_mod_ce[3:0] !== (pb_ce[0] ? 4'b1000 : 4'b0000)) mis++;
            if (pb_mod_ce[7:4] !== 4'b0000) mis++;
            if (cpu_mod_ce != 4'b0000) seen++;
            @(negedge clk);
            #1;
        end
        check("R9", "masked enable mismatches", mis, 0);
        check("R9", "masked cpu pulses seen", seen, 16);
        wr(A_CPU_MASK, 8'h0f);
        wr(A_PB_MASK0 + 4'd1, 8'h0f);
        mis = 0;
        for (int k = 0; k < 64; k++) begin
            if (cpu_mod_ce !== {4{cpu_ce}}) mis++;
            if (pb_mod_ce[7:4] !== {4{pb_ce[1]}}) mis++;
            @(negedge clk);
            #1;
        end
        check("R9", "re-enabled mismatches", mis, 0);

        finish_run();
    end
endmodule